// File: doc/BRIEF.md
# Parameterized Carry-Save Compressor Tree

This block adds many unsigned operands without resolving a carry chain. A set of operands, all the same width, is reduced to two redundant vectors, named sum and carry, whose modular total equals the modular total of every operand. A following carry-propagate adder, which lies outside this block, merges the two vectors.

The reduction works in levels. At each level the live operands are grouped in threes from the lowest index upward. Each group goes through a row of one-bit full adders, one per bit position, and becomes a sum vector and a carry vector shifted left by one. One or two operands that do not fill a group move on to the next level unchanged, placed after the group results. Levels repeat until two vectors remain.

All operands are zero-extended to the output width before the first level. The output stage is selected by a parameter. It is either a plain combinational path, or a single register that loads a new result when the input is marked valid and raises its own valid one clock later.

Top module: `csa_reduce_tree`

## Requirements
- R1: For every operand set, (sum_o + carry_o) mod 2^OUT_W equals the sum of all NUM_OPS operands, each zero-extended, mod 2^OUT_W. This holds for NUM_OPS of 3, 4, 7 and 9.
- R2: With REG_OUT = 0, sum_o and carry_o follow ops_i in the same cycle, and out_valid equals in_valid.
- R3: With REG_OUT = 1, a result whose in_valid is high at a rising clock edge appears on sum_o and carry_o after that edge. out_valid after each edge equals the in_valid sampled at that edge.
- R4: With REG_OUT = 1, an edge where in_valid is low leaves sum_o and carry_o unchanged, whatever ops_i carries.
- R5: With REG_OUT = 1, an edge where rst is high clears sum_o, carry_o and out_valid to zero. The reset is synchronous and active high.
- R6: With NUM_OPS = 2, sum_o equals operand 0 (bits IN_W-1:0 of ops_i) and carry_o equals operand 1 (the next IN_W bits), both zero-extended.
- R7: With NUM_OPS = 1, sum_o equals the operand zero-extended, and carry_o is zero.
- R8: With NUM_OPS of 3 or more, bit 0 of carry_o is always 0.
- R9: Operands at their maximum value (all ones) wrap modulo 2^OUT_W without error. With nine 8-bit operands of 0xFF and OUT_W = 12, the total is 0x8F7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Marks ops_i as holding a set to be reduced |
| ops_i | input | NUM_OPS*IN_W | Operands, operand k in bits k*IN_W +: IN_W |
| sum_o | output | OUT_W | Redundant sum vector |
| carry_o | output | OUT_W | Redundant carry vector, already shifted |
| out_valid | output | 1 | Marks sum_o and carry_o as holding a result |

## Verification
The assertions treat all operands as unsigned and require OUT_W to be at least IN_W, so zero extension loses no bits. The stimulus keeps to 8-bit operands with a 12-bit result. The registered checks assume in_valid is low while rst is high; the stimulus holds in_valid at zero across every reset. Operand values come from a fixed vector table and a linear feedback generator. The fixed table includes all-zero and all-ones sets, so wrap-around is covered.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

    // Number of vectors left after one level acting on n vectors:
    // each full group of three becomes two, leftovers pass through.
    function automatic int unsigned csa_next_count(int unsigned n);
        return (n / 3) * 2 + (n % 3);
    endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);
    always_comb begin
        s_o  = a_i ^ b_i ^ c_i;
        co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] cs_o
);
    logic [W-1:0] co;

    for (genvar k = 0; k < W; k++) begin : g_bit
        csa_fa u_fa (
            .a_i (a_i[k]),
            .b_i (b_i[k]),
            .c_i (c_i[k]),
            .s_o (s_o[k]),
            .co_o(co[k])
        );
    end

    // carry weighs twice its bit position; the top carry falls off at W bits
    assign cs_o = co << 1;
endmodule

// File: rtl/csa_level.sv
module csa_level
    import csa_tree_pkg::*;
#(
    parameter int N_IN = 9,
    parameter int W    = 12,
    localparam int N_OUT = csa_next_count(N_IN)
) (
    input  logic [N_IN-1:0][W-1:0]  ops_i,
    output logic [N_OUT-1:0][W-1:0] ops_o
);
    localparam int N_GRP  = N_IN / 3;
    localparam int N_LEFT = N_IN % 3;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        csa_row #(.W(W)) u_row (
            .a_i (ops_i[3*g]),
            .b_i (ops_i[3*g+1]),
            .c_i (ops_i[3*g+2]),
            .s_o (ops_o[2*g]),
            .cs_o(ops_o[2*g+1])
        );
    end

    for (genvar j = 0; j < N_LEFT; j++) begin : g_left
        assign ops_o[2*N_GRP+j] = ops_i[3*N_GRP+j];
    end
endmodule

// File: rtl/csa_tree_node.sv
module csa_tree_node
    import csa_tree_pkg::*;
#(
    parameter int N_IN = 9,
    parameter int W    = 12
) (
    input  logic [N_IN-1:0][W-1:0] ops_i,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           carry_o
);
    if (N_IN == 1) begin : g_single
        assign sum_o   = ops_i[0];
        assign carry_o = '0;
    end else if (N_IN == 2) begin : g_pair
        assign sum_o   = ops_i[0];
        assign carry_o = ops_i[1];
    end else begin : g_reduce
        localparam int N_NEXT = csa_next_count(N_IN);
        logic [N_NEXT-1:0][W-1:0] nxt;

        csa_level #(.N_IN(N_IN), .W(W)) u_level (
            .ops_i(ops_i),
            .ops_o(nxt)
        );

        csa_tree_node #(.N_IN(N_NEXT), .W(W)) u_next (
            .ops_i  (nxt),
            .sum_o  (sum_o),
            .carry_o(carry_o)
        );
    end
endmodule

// File: rtl/csa_reduce_tree.sv
module csa_reduce_tree #(
    parameter int NUM_OPS = 9,
    parameter int IN_W    = 8,
    parameter int OUT_W   = 12,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [NUM_OPS*IN_W-1:0] ops_i,
    output logic [OUT_W-1:0]        sum_o,
    output logic [OUT_W-1:0]        carry_o,
    output logic                    out_valid
);
    logic [NUM_OPS-1:0][OUT_W-1:0] ext;
    logic [OUT_W-1:0]              tree_sum;
    logic [OUT_W-1:0]              tree_carry;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_ext
        assign ext[k] = OUT_W'(ops_i[k*IN_W +: IN_W]);
    end

    csa_tree_node #(.N_IN(NUM_OPS), .W(OUT_W)) u_tree (
        .ops_i  (ext),
        .sum_o  (tree_sum),
        .carry_o(tree_carry)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [OUT_W-1:0] sum;
            logic [OUT_W-1:0] carry;
            logic             vld;
        } out_state_t;

        out_state_t st_d;
        out_state_t st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.sum   = tree_sum;
                st_d.carry = tree_carry;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= '0;
            else     st_q <= st_d;
        end

        assign sum_o     = st_q.sum;
        assign carry_o   = st_q.carry;
        assign out_valid = st_q.vld;
    end else begin : g_comb
        assign sum_o     = tree_sum;
        assign carry_o   = tree_carry;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/csa_reduce_tree_chk.sv
module csa_reduce_tree_chk #(
    parameter int NUM_OPS = 9,
    parameter int IN_W    = 8,
    parameter int OUT_W   = 12,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [NUM_OPS*IN_W-1:0] ops_i,
    input logic [OUT_W-1:0]        sum_o,
    input logic [OUT_W-1:0]        carry_o,
    input logic                    out_valid
);
    logic [OUT_W-1:0] ref_total;
    logic [OUT_W-1:0] out_total;

    always_comb begin
        ref_total = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            ref_total = ref_total + OUT_W'(ops_i[k*IN_W +: IN_W]);
        end
        out_total = sum_o + carry_o;
    end

    if (REG_OUT) begin : g_reg_props
        assert_sum_invariant_R1: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_total == $past(ref_total));
        assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> out_valid == $past(in_valid));
        assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(sum_o) && $stable(carry_o));
        assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (sum_o == '0) && (carry_o == '0) && !out_valid);
    end else begin : g_comb_props
        assert_sum_invariant_R1: assert property (@(posedge clk) disable iff (rst)
            out_total == ref_total);
        assert_valid_pass_R2: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end

    if (NUM_OPS >= 3) begin : g_lsb_prop
        assert_carry_lsb_R8: assert property (@(posedge clk) disable iff (rst)
            carry_o[0] == 1'b0);
    end
endmodule

bind csa_reduce_tree csa_reduce_tree_chk #(
    .NUM_OPS(NUM_OPS),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .ops_i    (ops_i),
    .sum_o    (sum_o),
    .carry_o  (carry_o),
    .out_valid(out_valid)
);

// File: tb/csa_reduce_tree_bench.sv
module csa_reduce_tree_bench;
    localparam int IN_W  = 8;
    localparam int OUT_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [8:0][IN_W-1:0] ops9 = '0;

    logic [OUT_W-1:0] s9, c9, s3, c3, s4, c4, s7, c7, s2, c2, s1, c1;
    logic v9, v3, v4, v7, v2, v1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    csa_reduce_tree #(.NUM_OPS(9), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b1)) u_csa_reduce_tree (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9),
        .sum_o(s9), .carry_o(c9), .out_valid(v9));
    csa_reduce_tree #(.NUM_OPS(3), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b0)) u_csa_reduce_tree_m3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9[2:0]),
        .sum_o(s3), .carry_o(c3), .out_valid(v3));
    csa_reduce_tree #(.NUM_OPS(4), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b0)) u_csa_reduce_tree_m4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9[3:0]),
        .sum_o(s4), .carry_o(c4), .out_valid(v4));
    csa_reduce_tree #(.NUM_OPS(7), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b0)) u_csa_reduce_tree_m7 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9[6:0]),
        .sum_o(s7), .carry_o(c7), .out_valid(v7));
    csa_reduce_tree #(.NUM_OPS(2), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b0)) u_csa_reduce_tree_m2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9[1:0]),
        .sum_o(s2), .carry_o(c2), .out_valid(v2));
    csa_reduce_tree #(.NUM_OPS(1), .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b0)) u_csa_reduce_tree_m1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ops_i(ops9[0]),
        .sum_o(s1), .carry_o(c1), .out_valid(v1));

    localparam logic [71:0] VEC [8] = '{
        72'h00_00_00_00_00_00_00_00_00,
        72'hFF_FF_FF_FF_FF_FF_FF_FF_FF,
        72'h01_02_03_04_05_06_07_08_09,
        72'hAA_55_AA_55_AA_55_AA_55_AA,
        72'h80_00_00_00_00_00_00_00_80,
        72'h00_00_FF_00_FF_00_FF_00_FF,
        72'h12_34_56_78_9A_BC_DE_F0_0F,
        72'h7F_80_7F_80_7F_80_7F_80_7F
    };

    function automatic logic [OUT_W-1:0] ref_sum(logic [8:0][IN_W-1:0] v, int n);
        logic [OUT_W-1:0] acc = '0;
        for (int k = 0; k < n; k++) acc = acc + OUT_W'(v[k]);
        return acc;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_comb();
        logic [OUT_W-1:0] t;
        t = s3 + c3; check(t == ref_sum(ops9, 3), "R1 m3", t, ref_sum(ops9, 3));
        t = s4 + c4; check(t == ref_sum(ops9, 4), "R1 m4", t, ref_sum(ops9, 4));
        t = s7 + c7; check(t == ref_sum(ops9, 7), "R1 m7", t, ref_sum(ops9, 7));
        check(v3 == in_valid, "R2 valid", v3, in_valid);
        check(s2 == OUT_W'(ops9[0]) && c2 == OUT_W'(ops9[1]), "R6 pair", {s2, c2},
              {OUT_W'(ops9[0]), OUT_W'(ops9[1])});
        check(s1 == OUT_W'(ops9[0]) && c1 == '0, "R7 single", {s1, c1}, {OUT_W'(ops9[0]), OUT_W'(0)});
        check(c3[0] == 1'b0 && c4[0] == 1'b0 && c7[0] == 1'b0, "R8 lsb", {c3[0], c4[0], c7[0]}, 0);
    endtask

    task automatic apply_and_check(logic [71:0] v);
        logic [OUT_W-1:0] exp9, t;
        @(negedge clk);
        ops9 = v;
        in_valid = 1'b1;
        exp9 = ref_sum(ops9, 9);
        #1 check_comb();
        @(posedge clk);
        #1;
        t = s9 + c9;
        check(t == exp9, "R1 m9", t, exp9);
        check(v9 == 1'b1, "R3 out_valid", v9, 1);
        check(c9[0] == 1'b0, "R8 m9 lsb", c9[0], 0);
    endtask

    initial begin
        logic [71:0] lfsr;
        logic [OUT_W-1:0] hs, hc, t;
        lfsr = 72'h1_2345_6789_ABCD_EF01;

        repeat (3) @(posedge clk);
        #1;
        check(s9 == '0 && c9 == '0 && v9 == 1'b0, "R5 reset state", {s9, c9, v9}, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) apply_and_check(VEC[i]);

        // R9: all ones wraps to a known total
        apply_and_check(VEC[1]);
        t = s9 + c9;
        check(t == 12'h8F7, "R9 wrap", t, 12'h8F7);

        // R4: idle edge holds outputs while operands change
        hs = s9; hc = c9;
        @(negedge clk);
        in_valid = 1'b0;
        ops9 = VEC[2];
        #1 check(v3 == 1'b0, "R2 valid low", v3, 0);
        @(posedge clk);
        #1;
        check(s9 == hs && c9 == hc, "R4 hold", {s9, c9}, {hs, hc});
        check(v9 == 1'b0, "R3 valid drop", v9, 0);

        // random sets
        for (int i = 0; i < 200; i++) begin
            for (int b = 0; b < 72; b++) lfsr = {lfsr[70:0], lfsr[71] ^ lfsr[65] ^ lfsr[24] ^ lfsr[18]};
            apply_and_check(lfsr);
        end

        // R5: reset in mid-run clears outputs
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(s9 == '0 && c9 == '0 && v9 == 1'b0, "R5 mid reset", {s9, c9, v9}, 0);
        @(negedge clk);
        rst = 1'b0;
        apply_and_check(VEC[6]);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule